// File: doc/BRIEF.md
# Instruction and Data Breakpoint Unit

This block watches a processor's instruction fetch stream and its load/store stream for addresses that software has marked as breakpoints. It holds a parameterised number of instruction-breakpoint address registers with one enable bit per slot. It also holds a parameterised number of data-breakpoint slots, and each of these has an address register and a control register. Software loads these registers through a simple write port that is selected by a register kind and a slot index.

Every cycle, the fetch address is compared in full against each enabled instruction slot. The load/store address is compared against each data slot under a high-order compare mask, and the slot only reports a hit for the access directions it is armed for. Both hit vectors are combinational from the current access, so a data hit is known before the access commits. Turning a hit into a debug exception is the job of a separate exception controller.

Top module: `bpu_breakpoint_unit`

## Requirements
- R1: After reset, every address, enable and control register is zero, and no hit output is asserted for any fetch or access.
- R2: Configuration writes are selected by `cfg_kind`: 0 writes the instruction enable mask, 1 writes the instruction address of slot `cfg_idx`, 2 writes the data address of slot `cfg_idx`, and 3 writes the data control of slot `cfg_idx`. An instruction slot hits when `fetch_valid` is high, its enable bit is set, and `fetch_addr` equals its address in every bit.
- R3: A write to the instruction enable mask keeps only bits [NI-1:0]. Bit i enables slot i, higher bits have no effect, and a slot whose bit is clear never hits.
- R4: In a data control word, bit 31 arms the slot for stores (`acc_is_store`=1) and bit 30 arms it for loads (`acc_is_store`=0). A slot with both bits clear never hits.
- R5: Data control bits [5:0] form the mask field. Field bit j set means address bit j is compared, field bit j clear means it is ignored, and address bits 6 and above are always compared.
- R6: A mask field that is not a run of ones down from bit 5 is cut at its highest zero bit. That bit and every bit below it are treated as ignored. For example, 6'b101111 acts as 6'b100000.
- R7: Each hit vector is one-hot, with the lowest-numbered matching slot winning. `ibrk_any` and `dbrk_any` are high exactly when any slot of their kind matches.
- R8: Hits are combinational in the cycle of the access. A configuration write takes effect from the cycle after its clock edge, and an access in the same cycle as the write is judged against the previous settings.
- R9: With `fetch_valid` or `acc_valid` low, the corresponding hit outputs are zero. A write whose `cfg_idx` does not name an existing slot of the selected kind changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Register kind selector |
| cfg_idx | input | IDXW | Slot index for the write |
| cfg_wdata | input | AW | Write data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | AW | Fetch address |
| acc_valid | input | 1 | Load/store address is valid this cycle |
| acc_is_store | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | AW | Load/store address |
| ibrk_hit | output | NI | One-hot instruction breakpoint hit |
| ibrk_any | output | 1 | Any instruction breakpoint hit |
| dbrk_hit | output | ND | One-hot data breakpoint hit |
| dbrk_any | output | 1 | Any data breakpoint hit |

## Verification
A configuration write and a data access can fall in the same cycle. The write lands at the clock edge, while the access is compared combinationally before that edge. The bench provokes this by rewriting a slot's address while it drives an access that matches the old address. It expects a hit in that cycle, then no hit on the old address and a hit on the new one in the following cycle.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

   typedef enum logic [1:0] {
      CFG_IEN   = 2'd0,
      CFG_IADDR = 2'd1,
      CFG_DADDR = 2'd2,
      CFG_DCTRL = 2'd3
   } cfg_kind_e;

endpackage

// File: rtl/bpu_mask_fix.sv
// Turns a raw mask field into a contiguous high-order compare mask.
module bpu_mask_fix #(
   parameter int AW = 32,
   parameter int MW = 6
) (
   input  logic [MW-1:0] field,
   output logic [AW-1:0] mask
);

   logic [MW-1:0] low;

   // Scan down from the top bit; once a zero is met, all lower bits drop out.
   always_comb begin
      logic keep;
      keep = 1'b1;
      for (int j = MW - 1; j >= 0; j--) begin
         keep   = keep & field[j];
         low[j] = keep;
      end
   end

   assign mask = {{(AW-MW){1'b1}}, low};

endmodule

// File: rtl/bpu_dbrk_slot.sv
// One data breakpoint slot: address, armed directions, mask, comparator.
module bpu_dbrk_slot #(
   parameter int AW     = 32,
   parameter int MW     = 6,
   parameter int SB_BIT = 31,
   parameter int LB_BIT = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_addr,
   input  logic          we_ctrl,
   input  logic [AW-1:0] wdata,
   input  logic          acc_valid,
   input  logic          acc_is_store,
   input  logic [AW-1:0] acc_addr,
   output logic          raw_hit
);

   logic [AW-1:0] addr_q;
   logic [MW-1:0] field_q;
   logic          st_en_q;
   logic          ld_en_q;
   logic [AW-1:0] mask;
   logic          dir_ok;
   logic          match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         field_q <= '0;
         st_en_q <= 1'b0;
         ld_en_q <= 1'b0;
      end else begin
         if (we_addr) addr_q <= wdata;
         if (we_ctrl) begin
            field_q <= wdata[MW-1:0];
            st_en_q <= wdata[SB_BIT];
            ld_en_q <= wdata[LB_BIT];
         end
      end
   end

   bpu_mask_fix #(.AW(AW), .MW(MW)) u_mask (
      .field (field_q),
      .mask  (mask)
   );

   assign dir_ok  = acc_is_store ? st_en_q : ld_en_q;
   assign match   = ((acc_addr ^ addr_q) & mask) == '0;
   assign raw_hit = acc_valid & dir_ok & match;

   // R4: a disarmed slot stays silent
   p_inactive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_en_q && !ld_en_q) |-> !raw_hit);
   // R4: direction gating
   p_dir_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_is_store && !st_en_q) |-> !raw_hit);
   // R5: bits above the field are always compared
   p_high_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
      raw_hit |-> (acc_addr[AW-1:MW] == addr_q[AW-1:MW]));
   // R6: the applied mask has no hole
   p_contig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((~mask) + 1'b1) & (~mask)) == '0);
   // R8: control write lands at the next edge
   p_ctrl_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we_ctrl |=> (st_en_q == $past(wdata[SB_BIT]) && field_q == $past(wdata[MW-1:0])));

endmodule

// File: rtl/bpu_ibrk_bank.sv
// Instruction breakpoint address registers, enable mask and comparators.
module bpu_ibrk_bank #(
   parameter int AW = 32,
   parameter int NI = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_en,
   input  logic [NI-1:0] we_addr,
   input  logic [AW-1:0] wdata,
   input  logic          fetch_valid,
   input  logic [AW-1:0] fetch_addr,
   output logic [NI-1:0] raw_hit
);

   logic [NI-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (we_en) en_q <= wdata[NI-1:0];
   end

   for (genvar i = 0; i < NI; i++) begin : g_slot
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          addr_q <= '0;
         else if (we_addr[i]) addr_q <= wdata;
      end
      assign raw_hit[i] = fetch_valid & en_q[i] & (fetch_addr == addr_q);
   end

   // R3: the enable write keeps only the low NI bits
   p_en_clip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      we_en |=> en_q == $past(wdata[NI-1:0]));
   // R9: no fetch, no hit
   p_idle_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_valid |-> raw_hit == '0);

endmodule

// File: rtl/bpu_prio.sv
// Keeps only the lowest-numbered set bit.
module bpu_prio #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !found) gnt[i] = 1'b1;
         found = found | req[i];
      end
   end

endmodule

// File: rtl/bpu_breakpoint_unit.sv
module bpu_breakpoint_unit
   import bpu_pkg::*;
#(
   parameter int AW     = 32,
   parameter int NI     = 3,
   parameter int ND     = 2,
   parameter int MW     = 6,
   parameter int SB_BIT = 31,
   parameter int LB_BIT = 30,
   localparam int MAXN  = (NI > ND) ? NI : ND,
   localparam int IDXW  = (MAXN > 1) ? $clog2(MAXN) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_kind,
   input  logic [IDXW-1:0] cfg_idx,
   input  logic [AW-1:0]   cfg_wdata,
   input  logic            fetch_valid,
   input  logic [AW-1:0]   fetch_addr,
   input  logic            acc_valid,
   input  logic            acc_is_store,
   input  logic [AW-1:0]   acc_addr,
   output logic [NI-1:0]   ibrk_hit,
   output logic            ibrk_any,
   output logic [ND-1:0]   dbrk_hit,
   output logic            dbrk_any
);

   // Elaboration-time parameter checks
   if (NI < 1 || NI > AW)            begin : g_bad_ni  $error("NI out of range"); end
   if (ND < 1)                       begin : g_bad_nd  $error("ND must be at least 1"); end
   if (MW < 1 || MW >= AW)           begin : g_bad_mw  $error("MW must lie in 1..AW-1"); end
   if (SB_BIT < MW || LB_BIT < MW)   begin : g_bad_bit $error("enable bits overlap mask field"); end
   if (SB_BIT == LB_BIT)             begin : g_same    $error("enable bits must differ"); end
   if (SB_BIT >= AW || LB_BIT >= AW) begin : g_wide    $error("enable bits exceed data width"); end

   cfg_kind_e     kind;
   logic [NI-1:0] i_we_addr;
   logic [ND-1:0] d_we_addr;
   logic [ND-1:0] d_we_ctrl;
   logic [NI-1:0] i_raw;
   logic [ND-1:0] d_raw;

   assign kind = cfg_kind_e'(cfg_kind);

   for (genvar i = 0; i < NI; i++) begin : g_idec
      assign i_we_addr[i] = cfg_we && kind == CFG_IADDR && cfg_idx == IDXW'(i);
   end

   bpu_ibrk_bank #(.AW(AW), .NI(NI)) u_ibank (
      .clk         (clk),
      .rst_n       (rst_n),
      .we_en       (cfg_we && kind == CFG_IEN),
      .we_addr     (i_we_addr),
      .wdata       (cfg_wdata),
      .fetch_valid (fetch_valid),
      .fetch_addr  (fetch_addr),
      .raw_hit     (i_raw)
   );

   for (genvar d = 0; d < ND; d++) begin : g_dslot
      assign d_we_addr[d] = cfg_we && kind == CFG_DADDR && cfg_idx == IDXW'(d);
      assign d_we_ctrl[d] = cfg_we && kind == CFG_DCTRL && cfg_idx == IDXW'(d);
      bpu_dbrk_slot #(.AW(AW), .MW(MW), .SB_BIT(SB_BIT), .LB_BIT(LB_BIT)) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .we_addr      (d_we_addr[d]),
         .we_ctrl      (d_we_ctrl[d]),
         .wdata        (cfg_wdata),
         .acc_valid    (acc_valid),
         .acc_is_store (acc_is_store),
         .acc_addr     (acc_addr),
         .raw_hit      (d_raw[d])
      );
   end

   bpu_prio #(.N(NI)) u_iprio (.req(i_raw), .gnt(ibrk_hit));
   bpu_prio #(.N(ND)) u_dprio (.req(d_raw), .gnt(dbrk_hit));

   assign ibrk_any = |i_raw;
   assign dbrk_any = |d_raw;

   // R7: one-hot outputs, flag agrees with vector
   p_ionehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ibrk_hit) && (ibrk_any == (ibrk_hit != '0)));
   p_donehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dbrk_hit) && (dbrk_any == (dbrk_hit != '0)));
   // R9: no access, no data hit
   p_idle_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!dbrk_any && dbrk_hit == '0));
   // R1: first cycle out of reset has nothing armed
   p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ibrk_hit == '0 && dbrk_hit == '0));

endmodule

// File: tb/tb_bpu_breakpoint_unit.sv
module tb_bpu_breakpoint_unit;

   localparam int AW = 32;
   localparam int NI = 3;
   localparam int ND = 2;
   localparam int IDXW = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [1:0]      cfg_kind = '0;
   logic [IDXW-1:0] cfg_idx = '0;
   logic [AW-1:0]   cfg_wdata = '0;
   logic            fetch_valid = 1'b0;
   logic [AW-1:0]   fetch_addr = '0;
   logic            acc_valid = 1'b0;
   logic            acc_is_store = 1'b0;
   logic [AW-1:0]   acc_addr = '0;
   logic [NI-1:0]   ibrk_hit;
   logic            ibrk_any;
   logic [ND-1:0]   dbrk_hit;
   logic            dbrk_any;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   localparam logic [31:0] SB = 32'h8000_0000;
   localparam logic [31:0] LB = 32'h4000_0000;

   always #10 clk = ~clk;

   bpu_breakpoint_unit #(.AW(AW), .NI(NI), .ND(ND)) dut (
      .clk, .rst_n, .cfg_we, .cfg_kind, .cfg_idx, .cfg_wdata,
      .fetch_valid, .fetch_addr, .acc_valid, .acc_is_store, .acc_addr,
      .ibrk_hit, .ibrk_any, .dbrk_hit, .dbrk_any
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] kind, input logic [IDXW-1:0] idx, input logic [31:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic fetch(input logic v, input logic [31:0] a,
                        input logic [NI-1:0] exp_hit, input string req);
      fetch_valid = v; fetch_addr = a;
      #2;
      check(req, {29'd0, ibrk_hit}, {29'd0, exp_hit});
      check(req, {31'd0, ibrk_any}, {31'd0, exp_hit != '0});
   endtask

   task automatic access(input logic v, input logic st, input logic [31:0] a,
                         input logic [ND-1:0] exp_hit, input string req);
      acc_valid = v; acc_is_store = st; acc_addr = a;
      #2;
      check(req, {30'd0, dbrk_hit}, {30'd0, exp_hit});
      check(req, {31'd0, dbrk_any}, {31'd0, exp_hit != '0});
   endtask

   task automatic t_reset;
      @(negedge clk);
      fetch(1'b1, 32'h0, 3'b000, "R1 fetch after reset");
      access(1'b1, 1'b0, 32'h0, 2'b00, "R1 load after reset");
      access(1'b1, 1'b1, 32'h0, 2'b00, "R1 store after reset");
   endtask

   task automatic t_ibrk;
      wr(2'd1, 2'd0, 32'h4000);
      wr(2'd1, 2'd1, 32'h4010);
      wr(2'd1, 2'd2, 32'h4020);
      wr(2'd0, 2'd0, 32'h5);
      fetch(1'b1, 32'h4000, 3'b001, "R2 slot0 hit");
      fetch(1'b1, 32'h4020, 3'b100, "R2 slot2 hit");
      fetch(1'b1, 32'h4004, 3'b000, "R2 near miss");
      fetch(1'b1, 32'h4010, 3'b000, "R3 disabled slot1");
      fetch(1'b0, 32'h4000, 3'b000, "R9 fetch invalid");
   endtask

   task automatic t_ien_clip;
      wr(2'd0, 2'd0, 32'hFFFF_FFF8);
      fetch(1'b1, 32'h4000, 3'b000, "R3 high enable bits ignored s0");
      fetch(1'b1, 32'h4020, 3'b000, "R3 high enable bits ignored s2");
      wr(2'd0, 2'd0, 32'h7);
      fetch(1'b1, 32'h4010, 3'b010, "R3 slot1 enabled");
   endtask

   task automatic t_iprio;
      wr(2'd1, 2'd1, 32'h4000);
      wr(2'd1, 2'd2, 32'h4000);
      fetch(1'b1, 32'h4000, 3'b001, "R7 lowest instr slot");
      wr(2'd0, 2'd0, 32'h6);
      fetch(1'b1, 32'h4000, 3'b010, "R7 next instr slot");
      fetch(1'b0, 32'h0, 3'b000, "R9 idle fetch");
   endtask

   task automatic t_dir;
      wr(2'd2, 2'd0, 32'h8000);
      wr(2'd3, 2'd0, SB | 32'h3F);
      access(1'b1, 1'b1, 32'h8000, 2'b01, "R4 store armed");
      access(1'b1, 1'b0, 32'h8000, 2'b00, "R4 load not armed");
      wr(2'd3, 2'd0, LB | 32'h3F);
      access(1'b1, 1'b0, 32'h8000, 2'b01, "R4 load armed");
      access(1'b1, 1'b1, 32'h8000, 2'b00, "R4 store not armed");
      wr(2'd3, 2'd0, 32'h3F);
      access(1'b1, 1'b0, 32'h8000, 2'b00, "R4 inactive load");
      access(1'b1, 1'b1, 32'h8000, 2'b00, "R4 inactive store");
   endtask

   task automatic t_mask;
      wr(2'd3, 2'd0, SB | LB | 32'h38);
      access(1'b1, 1'b0, 32'h8007, 2'b01, "R5 low 3 bits ignored");
      access(1'b1, 1'b0, 32'h8008, 2'b00, "R5 bit3 compared");
      wr(2'd3, 2'd0, SB | LB | 32'h00);
      access(1'b1, 1'b1, 32'h803F, 2'b01, "R5 full field ignored");
      access(1'b1, 1'b1, 32'h8040, 2'b00, "R5 bit6 compared");
      access(1'b1, 1'b1, 32'h1_8000, 2'b00, "R5 high bits compared");
      access(1'b0, 1'b1, 32'h8000, 2'b00, "R9 access invalid");
   endtask

   task automatic t_repair;
      wr(2'd3, 2'd0, SB | LB | 32'h2F);
      access(1'b1, 1'b0, 32'h8008, 2'b01, "R6 hole cuts bit3");
      access(1'b1, 1'b0, 32'h801F, 2'b01, "R6 low bits dropped");
      access(1'b1, 1'b0, 32'h8020, 2'b00, "R6 bit5 kept");
   endtask

   task automatic t_dprio;
      wr(2'd3, 2'd0, SB | LB | 32'h3F);
      wr(2'd2, 2'd1, 32'h8000);
      wr(2'd3, 2'd1, SB | LB | 32'h3F);
      access(1'b1, 1'b0, 32'h8000, 2'b01, "R7 lowest data slot");
      wr(2'd3, 2'd0, 32'h0);
      access(1'b1, 1'b0, 32'h8000, 2'b10, "R7 data slot1 alone");
      wr(2'd3, 2'd1, 32'h0);
      wr(2'd3, 2'd0, SB | LB | 32'h3F);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      cfg_we = 1'b1; cfg_kind = 2'd2; cfg_idx = 2'd0; cfg_wdata = 32'hA000;
      access(1'b1, 1'b0, 32'h8000, 2'b01, "R8 old address in write cycle");
      @(negedge clk);
      cfg_we = 1'b0;
      access(1'b1, 1'b0, 32'h8000, 2'b00, "R8 old address after write");
      access(1'b1, 1'b0, 32'hA000, 2'b01, "R8 new address after write");
   endtask

   task automatic t_oob;
      wr(2'd2, 2'd3, 32'h9000);
      wr(2'd3, 2'd2, 32'h0);
      access(1'b1, 1'b0, 32'hA000, 2'b01, "R9 out-of-range index ignored");
      access(1'b1, 1'b0, 32'h9000, 2'b00, "R9 no slot took address");
      wr(2'd1, 2'd3, 32'h4000);
      fetch(1'b1, 32'h4000, 3'b010, "R9 instr index 3 ignored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ibrk();
      t_ien_clip();
      t_iprio();
      t_dir();
      t_mask();
      t_repair();
      t_dprio();
      t_same_cycle();
      t_oob();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule